// File: doc/BRIEF.md
# Trace Packet Deserializer with Sideband End Markers

This block receives trace messages that arrive as bytes on an 8-bit data input, paired with a single framing line. The framing line is the only source of packet and message boundaries. The line sits at 1 while idle. It drops to 0 for every clock that carries a message byte. A short return to 1 marks where a variable-length packet ends. A single clock at 1 between runs of 0 ends one packet, and the message then carries on. Two or more clocks at 1 end the packet and the whole message together.

The last byte of a packet is sampled one clock before the end marker can be seen. The block cannot tell a packet end from a message end until it samples the second clock after the line rises. For this reason it holds each packet in an accumulator until that decision is made. It then presents the packet as a single wide word with a byte count, a packet-end strobe, a message-end strobe and a framing-error flag. Bytes are packed least significant byte first. A packet that runs past the accumulator capacity is truncated and flagged. The block does not interpret opcodes or split a packet into fields.

Top module: `trace_deser`

## Requirements
- R1: While reset is held and right after it is released, pktData, pktBytes, pktEnd, msgEnd and frameErr are all 0.
- R2: Within a message, each byte sampled with markIn at 0 is placed in the next free byte lane of the packet. The first byte goes in bits 7:0, the second in bits 15:8, and so on. Lanes that receive no byte read as 0.
- R3: In a message, a markIn sequence of 0, then a single 1, then 0 ends the current packet with pktEnd=1 and msgEnd=0. The byte sampled with that final 0 becomes the first byte of the next packet.
- R4: In a message, a markIn sequence of 0, then 1, then 1 ends the current packet and the message together: pktEnd and msgEnd are both 1 in the same cycle. msgEnd is never 1 without pktEnd.
- R5: pktEnd and msgEnd are one-cycle strobes. They are set by the clock edge that samples the second markIn value after the 0-to-1 transition, and never by the edge that samples the first 1.
- R6: pktBytes equals the number of bytes in the completed packet, from 1 up to 8, and is valid while pktEnd is 1.
- R7: If a packet holds more than 8 bytes, it is reported with its first 8 bytes, pktBytes=8 and frameErr=1. frameErr is 1 only together with pktEnd, and the following packet starts with no error.
- R8: After reset, markIn at 0 is ignored until markIn has been sampled at 1 on two consecutive clocks. Bytes sampled before that point never appear in any packet.
- R9: A message starts only when markIn goes to 0 after two or more clocks at 1. An idle line held at 1 produces no strobes.
- R10: Data sampled while markIn is 1 is ignored and never enters a packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 8 | Trace data byte |
| markIn | input | 1 | Framing line: 0 = data byte, 1 = idle or end marker |
| pktData | output | 64 | Completed packet, least significant byte first, held until the next packet |
| pktBytes | output | 4 | Byte count of the completed packet |
| pktEnd | output | 1 | One-cycle strobe: a packet has completed |
| msgEnd | output | 1 | One-cycle strobe: the message completed with this packet |
| frameErr | output | 1 | With pktEnd: the packet was longer than 8 bytes and was truncated |

## Verification
The hardest cases to reach are the ones where the marker's meaning depends on what comes after it. One is a lone 1 between two runs of 0, where a byte arrives on the same edge that closes the previous packet. The other is a stray 0 after reset, seen before the line has shown two 1s. Directed tasks drive exact markIn sequences: a single-1 gap, a double-1 gap, a 0-1-0 pattern right after reset, and a 10-byte run. The bench samples the strobes cycle by cycle around each marker. This confirms the end decision lands on the second marker clock, and that a byte arriving on the closing edge starts the next packet.

// File: rtl/tdes_pkg.sv
package tdes_pkg;

  // Strobes passed from the marker decoder to the datapath, one set per clock.
  typedef struct packed {
    logic appendByte;  // the byte on dataIn belongs to the current message
    logic emitPkt;     // close the packet held in the accumulator
    logic emitMsg;     // the closed packet also ends the message
  } ctrl_t;

  // Saturating count of consecutive sampled 1s on the framing line.
  localparam int RUN_W = 2;

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import tdes_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  markIn,
  output ctrl_t ctl
);

  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(2);

  logic [RUN_W-1:0] onesRun;
  logic [RUN_W-1:0] onesRunNext;
  logic inMsg;
  logic inMsgNext;

  // onesRun starts at 0, so a 0 cannot start a message before two 1s are seen.
  always_comb begin
    if (markIn) onesRunNext = (onesRun >= RUN_SAT) ? RUN_SAT : onesRun + RUN_ONE;
    else        onesRunNext = '0;
  end

  always_comb begin
    ctl       = '0;
    inMsgNext = inMsg;
    if (!inMsg) begin
      if (!markIn && onesRun == RUN_SAT) begin
        ctl.appendByte = 1'b1;
        inMsgNext      = 1'b1;
      end
    end else if (!markIn) begin
      ctl.appendByte = 1'b1;
      ctl.emitPkt    = (onesRun == RUN_ONE);
    end else if (onesRun == RUN_ONE) begin
      ctl.emitPkt = 1'b1;
      ctl.emitMsg = 1'b1;
      inMsgNext   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      onesRun <= '0;
      inMsg   <= 1'b0;
    end else begin
      onesRun <= onesRunNext;
      inMsg   <= inMsgNext;
    end
  end

  // A byte is only taken while the framing line is low.
  assert_append_low_only_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.appendByte |-> !markIn);

  // Opening a message needs the two previous samples at 1.
  assert_start_after_two_ones_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.appendByte && !inMsg) |-> ($past(markIn) && $past(markIn, 2)));

  // A close decision always follows a 1 that came after a 0.
  assert_close_after_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.emitPkt |-> ($past(markIn) && !$past(markIn, 2)));

endmodule

// File: rtl/trace_dp.sv
module trace_dp
  import tdes_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 8,
  localparam int PKT_W    = DATA_W * MAX_BYTES,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrl_t             ctl,
  output logic [PKT_W-1:0]  pktData,
  output logic [CNT_W-1:0]  pktBytes,
  output logic              pktEnd,
  output logic              msgEnd,
  output logic              frameErr
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MAX_BYTES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [PKT_W-1:0] accData;
  logic [CNT_W-1:0] accCount;
  logic             accOvf;

  // One register per byte lane; lane i loads when it is the next free slot.
  for (genvar i = 0; i < MAX_BYTES; i++) begin : gLane
    logic [DATA_W-1:0] laneReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneReg <= '0;
      end else if (ctl.emitPkt) begin
        laneReg <= (ctl.appendByte && i == 0) ? dataIn : '0;
      end else if (ctl.appendByte && accCount == CNT_W'(i)) begin
        laneReg <= dataIn;
      end
    end
    assign accData[i*DATA_W +: DATA_W] = laneReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accCount <= '0;
      accOvf   <= 1'b0;
    end else if (ctl.emitPkt) begin
      accCount <= ctl.appendByte ? CNT_ONE : '0;
      accOvf   <= 1'b0;
    end else if (ctl.appendByte) begin
      if (accCount == CNT_FULL) accOvf   <= 1'b1;
      else                      accCount <= accCount + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pktData  <= '0;
      pktBytes <= '0;
      pktEnd   <= 1'b0;
      msgEnd   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      pktEnd   <= ctl.emitPkt;
      msgEnd   <= ctl.emitMsg;
      frameErr <= ctl.emitPkt & accOvf;
      if (ctl.emitPkt) begin
        pktData  <= accData;
        pktBytes <= accCount;
      end
    end
  end

  assert_msg_with_pkt_R4: assert property (@(posedge clk) disable iff (!rstN)
    msgEnd |-> pktEnd);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |=> !pktEnd);

  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |-> (pktBytes != '0 && pktBytes <= CNT_FULL));

  assert_err_on_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> (pktEnd && pktBytes == CNT_FULL));

endmodule

// File: rtl/trace_deser.sv
module trace_deser
  import tdes_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 8,
  localparam int PKT_W    = DATA_W * MAX_BYTES,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              markIn,
  output logic [PKT_W-1:0]  pktData,
  output logic [CNT_W-1:0]  pktBytes,
  output logic              pktEnd,
  output logic              msgEnd,
  output logic              frameErr
);

  ctrl_t ctl;

  trace_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .markIn (markIn),
    .ctl    (ctl)
  );

  trace_dp #(
    .DATA_W    (DATA_W),
    .MAX_BYTES (MAX_BYTES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .ctl      (ctl),
    .pktData  (pktData),
    .pktBytes (pktBytes),
    .pktEnd   (pktEnd),
    .msgEnd   (msgEnd),
    .frameErr (frameErr)
  );

endmodule

// File: tb/tb_trace_deser.sv
module tb_trace_deser;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        markIn = 1'b1;
  logic [63:0] pktData;
  logic [3:0]  pktBytes;
  logic        pktEnd, msgEnd, frameErr;

  int errors = 0;
  int checks = 0;

  // Record of completed packets, captured at the falling edge.
  int          capN = 0;
  int          msgN = 0;
  logic [63:0] capData [8];
  logic [3:0]  capBytes [8];
  logic        capErr [8];
  logic        capMsg [8];

  trace_deser dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .markIn(markIn),
    .pktData(pktData), .pktBytes(pktBytes), .pktEnd(pktEnd),
    .msgEnd(msgEnd), .frameErr(frameErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (msgEnd) msgN++;
    if (pktEnd && capN < 8) begin
      capData[capN]  = pktData;
      capBytes[capN] = pktBytes;
      capErr[capN]   = frameErr;
      capMsg[capN]   = msgEnd;
      capN++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one sample; returns after the edge that samples it, outputs updated.
  task automatic step(input logic m, input logic [7:0] d);
    @(negedge clk);
    markIn = m;
    dataIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 8'hEE);
  endtask

  task automatic clearCap();
    @(negedge clk);
    capN = 0;
    msgN = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    markIn = 1'b1;
    step(1'b1, 8'h00);
    step(1'b1, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    capN = 0;
    msgN = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk); #1;
    check(pktData == 0 && pktBytes == 0 && !pktEnd && !msgEnd && !frameErr,
          "R1 outputs in reset", {pktEnd, msgEnd, frameErr}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(pktData == 0 && !pktEnd && !msgEnd && !frameErr,
          "R1 outputs after release", pktData, 0);
  endtask

  task automatic t_single();
    clearCap();
    idle(3);
    step(1'b0, 8'hA1); step(1'b0, 8'hB2); step(1'b0, 8'hC3);
    idle(3);
    check(capN == 1, "R4 one packet", capN, 1);
    check(capData[0] == 64'hC3B2A1, "R2 lsb-first data", capData[0], 64'hC3B2A1);
    check(capBytes[0] == 3, "R6 count 3", capBytes[0], 3);
    check(capMsg[0] && msgN == 1, "R4 message end with packet", msgN, 1);
  endtask

  task automatic t_twoPkt();
    clearCap();
    idle(2);
    step(1'b0, 8'h11); step(1'b0, 8'h22);
    step(1'b1, 8'h99);                 // single marker, data must be dropped
    step(1'b0, 8'h33); step(1'b0, 8'h44); step(1'b0, 8'h55);
    idle(3);
    check(capN == 2, "R3 two packets", capN, 2);
    check(capData[0] == 64'h2211 && !capMsg[0], "R3 first packet no msg end", capData[0], 64'h2211);
    check(capData[1] == 64'h554433, "R3 byte on closing edge starts next packet", capData[1], 64'h554433);
    check(capData[1][31:24] != 8'h99 && capData[0][23:16] != 8'h99,
          "R10 marker data ignored", capData[1], 64'h554433);
    check(capMsg[1] && msgN == 1, "R4 second packet ends msg", msgN, 1);
  endtask

  task automatic t_timing();
    clearCap();
    idle(2);
    step(1'b0, 8'h5A);
    check(!pktEnd, "R5 no strobe on byte", pktEnd, 0);
    step(1'b1, 8'h00);
    check(!pktEnd && !msgEnd, "R5 no strobe on first marker", {pktEnd, msgEnd}, 0);
    step(1'b1, 8'h00);
    check(pktEnd && msgEnd, "R5 strobes on second marker", {pktEnd, msgEnd}, 2'b11);
    check(pktBytes == 1 && pktData == 64'h5A, "R6 count 1", pktBytes, 1);
    step(1'b1, 8'h00);
    check(!pktEnd && !msgEnd, "R5 strobe lasts one cycle", {pktEnd, msgEnd}, 0);
  endtask

  task automatic t_overflow();
    clearCap();
    idle(2);
    for (int i = 1; i <= 10; i++) step(1'b0, 8'(i));
    step(1'b1, 8'h00);
    step(1'b0, 8'h77);
    idle(3);
    check(capN == 2, "R7 two packets", capN, 2);
    check(capData[0] == 64'h0807060504030201, "R7 truncated data", capData[0], 64'h0807060504030201);
    check(capBytes[0] == 8 && capErr[0], "R7 count 8 and error", {capBytes[0], capErr[0]}, {4'd8, 1'b1});
    check(!capErr[1] && capBytes[1] == 1 && capData[1] == 64'h77,
          "R7 next packet clean", capData[1], 64'h77);
  endtask

  task automatic t_preArm();
    doReset();
    step(1'b0, 8'hD1); step(1'b0, 8'hD2);
    step(1'b1, 8'h00);
    step(1'b0, 8'hD3);
    step(1'b1, 8'h00);
    step(1'b1, 8'h00);
    step(1'b1, 8'h00);
    check(capN == 0 && msgN == 0, "R8 early zeros ignored", capN, 0);
    step(1'b0, 8'h42);
    idle(3);
    check(capN == 1 && capData[0] == 64'h42, "R8 message after two ones", capData[0], 64'h42);
  endtask

  task automatic t_idle();
    clearCap();
    for (int i = 0; i < 20; i++) step(1'b1, 8'(i * 7));
    check(capN == 0 && msgN == 0, "R9 idle gives no strobes", capN, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_twoPkt();
    t_timing();
    t_overflow();
    t_preArm();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule